// File: doc/BRIEF.md
# Byte-Wide SPI Master with Status Flags

This block is a byte-oriented serial peripheral interface master driven by a three-register bus interface. Software writes a control register to pick the enable state, the master role, the interrupt enable and a two-bit rate code. It writes a byte to the data register to start a transfer. The block makes a serial clock from the system clock through a divider, shifts the byte out most significant bit first in SPI mode 0 (SCK idles low, data is sampled on the rising edge) and gathers the reply from MISO into a receive buffer.

The status register has a completion flag, a collision flag and a speed-doubling bit. The speed-doubling bit joins the rate code to pick the divider, and the resulting table is not monotonic. Each flag is cleared by a two-step sequence: software reads the status register while that flag is set, and then accesses the data register. The completion flag drives an interrupt request, and an acknowledge input also clears it. While the slave-select pin is configured as an input and is pulled low, the block treats this as a mode fault: it drops out of master mode, aborts the byte in flight and flags completion.

Register select codes: 0 is control, 1 is status, 2 is data.

Top module: `spi_byte_master`

## Requirements
- R1: The SCK period in system clocks is chosen by {status bit 0, control bits 1:0}. The codes map as follows: 000 to 4, 001 to 16, 010 to 64, 011 to 128, 100 to 2, 101 to 8, 110 to 32, 111 to 64.
- R2: A data-register write starts a transfer when control bit 6 (enable) and bit 4 (master) are both set and no transfer is running. The block then sends exactly 8 SCK pulses, with MOSI carrying the written byte most significant bit first. MOSI changes only while SCK is low. SCK rests low between transfers.
- R3: A read of the data register returns the last fully received byte, sampled from MISO on SCK rising edges, first bit as most significant. It reads zero after reset.
- R4: Status bit 7 (complete) sets when a transfer finishes.
- R5: irq is high exactly while status bit 7, control bit 7 (interrupt enable) and global_ie are all high.
- R6: A one-cycle pulse on irq_ack clears status bit 7.
- R7: A data-register write while a transfer runs sets status bit 6 (collision). That write is discarded: the byte in flight is sent unchanged and no further transfer follows.
- R8: A data-register access clears a status flag only if it was preceded by a status read that saw that flag set. A flag that sets after the status read survives that access.
- R9: While control bit 4 is set, slave_sel_n low together with slave_sel_is_input high clears control bit 4, aborts the transfer with SCK left low, and sets status bit 7.
- R10: Status bits 5:1 always read zero. Bits 7 and 6 ignore status writes. Bit 0 is read/write. The control register, status register and SCK all reset to zero.
- R11: A data-register write while enable or master is clear produces no SCK pulse and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_rd | input | 1 | Register read strobe, one cycle per access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| global_ie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt taken, clears the complete flag |
| irq | output | 1 | Interrupt request |
| slave_sel_n | input | 1 | Slave-select pin level |
| slave_sel_is_input | input | 1 | Slave-select pin is configured as an input |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |

## Verification
The assertions assume that reg_rd and reg_wr are never high in the same cycle, that each strobe lasts a single cycle, and that the rate bits stay unchanged while a byte is being shifted. The stimulus drives every register access as a one-cycle strobe at the falling clock edge, with idle cycles between accesses, and it changes the rate only between transfers. The bench plays the slave itself: it moves MISO after each falling SCK edge, records MOSI on each rising edge, and raises the slave-select fault only through a directed sequence.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;

    localparam int BYTE_W  = 8;
    localparam int DIV_MAX = 128;
    localparam int DIV_W   = $clog2(DIV_MAX) + 1;
    localparam int HALF_W  = $clog2(DIV_MAX / 2) + 1;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       irq_en;
        logic       enable;
        logic       rsv5;
        logic       master;
        logic [1:0] rsv3_2;
        logic [1:0] rate;
    } ctrl_t;

    typedef struct packed {
        logic       done;
        logic       coll;
        logic [4:0] rsv;
        logic       dbl;
    } stat_t;

    function automatic logic [DIV_W-1:0] sck_divisor(input logic dbl, input logic [1:0] rate);
        logic [DIV_W-1:0] d;
        case ({dbl, rate})
            3'b000:  d = DIV_W'(4);
            3'b001:  d = DIV_W'(16);
            3'b010:  d = DIV_W'(64);
            3'b011:  d = DIV_W'(128);
            3'b100:  d = DIV_W'(2);
            3'b101:  d = DIV_W'(8);
            3'b110:  d = DIV_W'(32);
            default: d = DIV_W'(64);
        endcase
        return d;
    endfunction

endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] half,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;
    logic             at_end;

    assign at_end = (cnt == half - CNT_W'(1));
    assign tick   = run && at_end;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (at_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] load_data,
    input  logic         tick,
    input  logic         abort,
    input  logic         miso,
    output logic         busy,
    output logic         sck,
    output logic         mosi,
    output logic         finish,
    output logic [W-1:0] rx_byte
);
    localparam int BC_W = $clog2(W);

    logic [W-1:0]    tx_sh;
    logic [W-1:0]    rx_sh;
    logic [BC_W-1:0] bit_cnt;

    assign mosi = tx_sh[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            sck     <= 1'b0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            rx_byte <= '0;
            bit_cnt <= '0;
            finish  <= 1'b0;
        end else begin
            finish <= 1'b0;
            if (abort) begin
                busy <= 1'b0;
                sck  <= 1'b0;
            end else if (start && !busy) begin
                busy    <= 1'b1;
                sck     <= 1'b0;
                tx_sh   <= load_data;
                bit_cnt <= '0;
            end else if (busy && tick) begin
                if (!sck) begin
                    sck   <= 1'b1;
                    rx_sh <= {rx_sh[W-2:0], miso};
                end else begin
                    sck     <= 1'b0;
                    tx_sh   <= {tx_sh[W-2:0], 1'b0};
                    bit_cnt <= bit_cnt + BC_W'(1);
                    if (bit_cnt == BC_W'(W - 1)) begin
                        busy    <= 1'b0;
                        rx_byte <= rx_sh;
                        finish  <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_flags.sv
module spi_flags (
    input  logic clk,
    input  logic rst,
    input  logic stat_rd,
    input  logic stat_wr,
    input  logic dbl_wdata,
    input  logic data_acc,
    input  logic done_evt,
    input  logic coll_evt,
    input  logic irq_ack,
    output logic done,
    output logic coll,
    output logic dbl
);
    logic arm_done;
    logic arm_coll;

    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b0;
            coll     <= 1'b0;
            dbl      <= 1'b0;
            arm_done <= 1'b0;
            arm_coll <= 1'b0;
        end else begin
            if (stat_wr) dbl <= dbl_wdata;

            if (stat_rd && done) arm_done <= 1'b1;
            if (stat_rd && coll) arm_coll <= 1'b1;
            if (data_acc) begin
                arm_done <= 1'b0;
                arm_coll <= 1'b0;
            end
            if (irq_ack) arm_done <= 1'b0;

            if (done_evt) begin
                done <= 1'b1;
            end else if (irq_ack || (data_acc && arm_done)) begin
                done <= 1'b0;
            end

            if (coll_evt) begin
                coll <= 1'b1;
            end else if (data_acc && arm_coll) begin
                coll <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spi_master_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   reg_addr,
    input  logic         reg_wr,
    input  logic         reg_rd,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic         global_ie,
    input  logic         irq_ack,
    output logic         irq,
    input  logic         slave_sel_n,
    input  logic         slave_sel_is_input,
    input  logic         miso,
    output logic         sck,
    output logic         mosi
);
    reg_sel_e         sel;
    ctrl_t            ctrl;
    stat_t            stat;
    logic             xfer_busy;
    logic             xfer_finish;
    logic             mode_fault;
    logic             flag_done;
    logic             flag_coll;
    logic             dbl_speed;
    logic             div_tick;
    logic             start_xfer;
    logic [W-1:0]     rx_byte;
    logic [DIV_W-1:0] divisor;
    logic [HALF_W-1:0] half_period;

    assign sel         = reg_sel_e'(reg_addr);
    assign mode_fault  = ctrl.master && slave_sel_is_input && !slave_sel_n;
    assign start_xfer  = reg_wr && (sel == SEL_DATA) && ctrl.enable && ctrl.master
                         && !xfer_busy && !mode_fault;
    assign divisor     = sck_divisor(dbl_speed, ctrl.rate);
    assign half_period = HALF_W'(divisor >> 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else begin
            if (reg_wr && sel == SEL_CTRL) begin
                ctrl        <= '0;
                ctrl.irq_en <= reg_wdata[7];
                ctrl.enable <= reg_wdata[6];
                ctrl.master <= reg_wdata[4];
                ctrl.rate   <= reg_wdata[1:0];
            end
            if (mode_fault) ctrl.master <= 1'b0;
        end
    end

    spi_clk_div #(.CNT_W(HALF_W)) div_i (
        .clk  (clk),
        .rst  (rst),
        .run  (xfer_busy),
        .half (half_period),
        .tick (div_tick)
    );

    spi_shifter #(.W(W)) shf_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start_xfer),
        .load_data (reg_wdata),
        .tick      (div_tick),
        .abort     (mode_fault),
        .miso      (miso),
        .busy      (xfer_busy),
        .sck       (sck),
        .mosi      (mosi),
        .finish    (xfer_finish),
        .rx_byte   (rx_byte)
    );

    spi_flags flg_i (
        .clk       (clk),
        .rst       (rst),
        .stat_rd   (reg_rd && sel == SEL_STAT),
        .stat_wr   (reg_wr && sel == SEL_STAT),
        .dbl_wdata (reg_wdata[0]),
        .data_acc  ((reg_rd || reg_wr) && sel == SEL_DATA),
        .done_evt  (xfer_finish || mode_fault),
        .coll_evt  (reg_wr && sel == SEL_DATA && xfer_busy),
        .irq_ack   (irq_ack),
        .done      (flag_done),
        .coll      (flag_coll),
        .dbl       (dbl_speed)
    );

    always_comb begin
        stat      = '0;
        stat.done = flag_done;
        stat.coll = flag_coll;
        stat.dbl  = dbl_speed;
    end

    always_comb begin
        case (sel)
            SEL_CTRL: reg_rdata = W'(ctrl);
            SEL_STAT: reg_rdata = W'(stat);
            SEL_DATA: reg_rdata = rx_byte;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = flag_done && ctrl.irq_en && global_ie;

endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] reg_addr,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [7:0] reg_rdata,
    input logic       global_ie,
    input logic       irq,
    input logic       sck,
    input logic       mosi,
    input logic       busy,
    input logic       fault,
    input logic       finish,
    input logic       done,
    input logic       coll
);
    a_r2_sck_rests_low: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sck);

    a_r2_mosi_steady_while_high: assert property (@(posedge clk) disable iff (rst)
        (busy && sck && $past(sck) && $past(busy)) |-> $stable(mosi));

    a_r4_finish_sets_done: assert property (@(posedge clk) disable iff (rst)
        finish |=> done);

    a_r5_irq_needs_done: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 2'd1 && !reg_rdata[7]) |-> !irq);

    a_r5_irq_needs_global: assert property (@(posedge clk) disable iff (rst)
        !global_ie |-> !irq);

    a_r7_busy_write_collides: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd2 && busy) |=> coll);

    a_r9_fault_aborts: assert property (@(posedge clk) disable iff (rst)
        fault |=> (!busy && !sck && done));

    a_r10_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 2'd1) |-> (reg_rdata[5:1] == 5'd0));
endmodule

bind spi_byte_master spi_byte_master_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .global_ie (global_ie),
    .irq       (irq),
    .sck       (sck),
    .mosi      (mosi),
    .busy      (xfer_busy),
    .fault     (mode_fault),
    .finish    (xfer_finish),
    .done      (flag_done),
    .coll      (flag_coll)
);

// File: tb/spi_byte_master_tb_top.sv
module spi_byte_master_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] reg_addr = 2'd3;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       global_ie = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq;
    logic       slave_sel_n = 1'b1;
    logic       slave_sel_is_input = 1'b0;
    logic       miso;
    logic       sck;
    logic       mosi;

    always #2 clk = ~clk;

    spi_byte_master dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .global_ie(global_ie),
        .irq_ack(irq_ack), .irq(irq), .slave_sel_n(slave_sel_n),
        .slave_sel_is_input(slave_sel_is_input), .miso(miso), .sck(sck), .mosi(mosi)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // slave model
    logic [7:0] slave_tx = 8'd0;
    int fall_cnt = 0;
    int fall_base = 0;
    int rise_cnt = 0;
    int t_prev = 0;
    int t_last = 0;
    logic [7:0] cap = 8'd0;

    always @(negedge sck) fall_cnt++;
    always @(posedge sck) begin
        #1;
        rise_cnt++;
        cap    = {cap[6:0], mosi};
        t_prev = t_last;
        t_last = cyc;
    end
    assign miso = ((fall_cnt - fall_base) < 8) ? slave_tx[7 - (fall_cnt - fall_base)] : 1'b0;

    function automatic int exp_div(input logic [2:0] code);
        case (code)
            3'd0: return 4;    3'd1: return 16;
            3'd2: return 64;   3'd3: return 128;
            3'd4: return 2;    3'd5: return 8;
            3'd6: return 32;   default: return 64;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd3;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; reg_addr = 2'd3;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm_slave(input logic [7:0] b);
        @(negedge clk);
        slave_tx  = b;
        fall_base = fall_cnt;
    endtask

    task automatic wait_done(output logic [7:0] s);
        s = 8'd0;
        for (int i = 0; i < 3000; i++) begin
            rd(2'd1, s);
            if (s[7]) break;
        end
    endtask

    logic [7:0] v;
    int r0;

    initial begin
        void'($urandom(32'd2024));
        idle(3);
        rst = 1'b0;
        idle(1);

        // reset state
        rd(2'd0, v); check("R10 ctrl reset", v, 8'h00);
        rd(2'd1, v); check("R10 status reset", v, 8'h00);
        rd(2'd2, v); check("R3 data reset", v, 8'h00);
        check("R10 sck reset", sck, 0);
        check("R5 irq reset", irq, 0);

        // R10: status write touches only bit 0
        wr(2'd1, 8'hFF);
        rd(2'd1, v); check("R10 status write", v, 8'h01);
        wr(2'd1, 8'h00);
        rd(2'd1, v); check("R10 status clear dbl", v, 8'h00);

        // R11: writes ignored when not enabled or not master
        r0 = rise_cnt;
        wr(2'd0, 8'h10); wr(2'd2, 8'h5A); idle(100);
        wr(2'd0, 8'h40); wr(2'd2, 8'h5A); idle(100);
        check("R11 no sck pulses", rise_cnt - r0, 0);
        rd(2'd1, v); check("R11 no flags", v, 8'h00);

        // random transfers: R1 R2 R3 R4 R8 R5
        for (int it = 0; it < 16; it++) begin
            logic [2:0] code;
            logic [7:0] txb, rxb;
            code = (it < 8) ? 3'(it) : 3'($urandom_range(0, 7));
            txb  = 8'($urandom);
            rxb  = 8'($urandom);
            wr(2'd0, {6'b010100, code[1:0]});
            wr(2'd1, {7'd0, code[2]});
            arm_slave(rxb);
            r0 = rise_cnt;
            wr(2'd2, txb);
            wait_done(v);
            check("R4 complete flag", v, {7'h40, code[2]} & 8'h81);
            check("R1 sck period", t_last - t_prev, exp_div(code));
            check("R2 pulse count", rise_cnt - r0, 8);
            check("R2 mosi byte", cap, txb);
            check("R2 sck rests low", sck, 0);
            check("R5 irq masked", irq, 0);
            rd(2'd2, v); check("R3 received byte", v, rxb);
            rd(2'd1, v); check("R8 flag cleared", v, {7'd0, code[2]});
        end

        // R7 and R8: collision, and a flag set after the status read
        wr(2'd0, 8'h53); wr(2'd1, 8'h00);
        arm_slave(8'h3C);
        r0 = rise_cnt;
        wr(2'd2, 8'hA5);
        idle(100);
        wr(2'd2, 8'h0F);
        rd(2'd1, v); check("R7 collision flag", v, 8'h40);
        idle(1200);
        check("R7 byte unchanged", cap, 8'hA5);
        check("R7 no extra transfer", rise_cnt - r0, 8);
        rd(2'd2, v); check("R3 received after collision", v, 8'h3C);
        rd(2'd1, v); check("R8 late flag survives", v, 8'h80);
        rd(2'd2, v);
        rd(2'd1, v); check("R8 complete cleared", v, 8'h00);

        // R8: data access without prior status read clears nothing
        wr(2'd0, 8'h50); wr(2'd1, 8'h01);
        arm_slave(8'h99);
        wr(2'd2, 8'h66);
        idle(40);
        rd(2'd2, v); check("R3 fast byte", v, 8'h99);
        rd(2'd1, v); check("R8 unarmed access keeps flag", v, 8'h81);
        rd(2'd2, v);

        // R5 and R6
        wr(2'd0, 8'hD0);
        global_ie = 1'b1;
        arm_slave(8'h12);
        wr(2'd2, 8'h34);
        idle(40);
        check("R5 irq asserted", irq, 1);
        @(negedge clk); global_ie = 1'b0; #1;
        check("R5 irq needs global enable", irq, 0);
        @(negedge clk); global_ie = 1'b1; #1;
        check("R5 irq back", irq, 1);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0; #1;
        check("R6 irq cleared by ack", irq, 0);
        rd(2'd1, v); check("R6 flag cleared by ack", v, 8'h01);
        global_ie = 1'b0;

        // R9: mode fault mid-transfer
        wr(2'd0, 8'h53); wr(2'd1, 8'h00);
        arm_slave(8'hF0);
        wr(2'd2, 8'hC3);
        idle(200);
        @(negedge clk); slave_sel_is_input = 1'b1; slave_sel_n = 1'b0;
        @(negedge clk); slave_sel_n = 1'b1;
        r0 = rise_cnt;
        idle(400);
        check("R9 sck stopped", rise_cnt - r0, 0);
        check("R9 sck low", sck, 0);
        rd(2'd0, v); check("R9 master cleared", v, 8'h43);
        rd(2'd1, v); check("R9 complete set", v, 8'h80);
        rd(2'd2, v);
        rd(2'd1, v); check("R8 fault flag cleared", v, 8'h00);
        slave_sel_is_input = 1'b0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 190000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule